// File: doc/BRIEF.md
# Pin Edge Capture and Interrupt Router

This block watches up to 128 general-purpose pins. Each pin comes in asynchronous, so it first passes through a two-flop synchronizer. The block then compares the synchronized level with its copy from the previous cycle. An edge on a pin configured as an input sets a sticky bit in a status vector, provided the enable for that edge direction is on. Software clears status bits by pulsing a write-one-to-clear mask.

The status vector is reduced onto three interrupt lines:
- pin 0 has a dedicated line;
- pin 1 has a dedicated line;
- every other pin shares one line.

Separately, a fixed bitmap marks which pins may wake a halted processor. A level change on such a pin, while it is an input and the halted flag is high, produces a one-cycle wake pulse. Register decoding and storage of the configuration live outside this block.

Top module: `gpio_edge_router`

## Requirements
- R1: A low-to-high change of a pin sets its status bit when the pin's direction bit is 0 (input) and its rise enable is 1. The bit appears in `edge_status` on the third rising clock edge after the pin input changes.
- R2: A high-to-low change of a pin sets its status bit when the pin's direction bit is 0 and its fall enable is 1, with the same three-edge latency.
- R3: A pin whose direction bit is 1 (output) never sets a status bit, whatever its level changes and enables.
- R4: Status bits stay set until cleared. A 1 in `clr_mask` during a cycle clears that status bit at the next clock edge; bits with 0 in the mask are untouched.
- R5: If an enabled edge event and a clear hit the same bit in the same cycle, the bit ends set.
- R6: `irq_pin0` equals status bit 0 and `irq_pin1` equals status bit 1.
- R7: `irq_shared` is the OR of status bits 2 to 127.
- R8: Pin p belongs to bank p/32, bit p%32. The wake masks for banks 0 to 3 are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F. When `cpu_halted` is 1 and a synchronized input pin inside the mask changes level, `wake_req` is high for exactly one cycle, on the same edge at which status would update.
- R9: No wake pulse is produced by a change while `cpu_halted` is 0. Likewise, no pulse comes from a pin outside the wake mask or from a pin configured as an output.
- R10: After reset, the status vector, all interrupt lines and `wake_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_async | input | 128 | Raw pin levels, asynchronous |
| dir_out | input | 128 | Per-pin direction, 1 = output |
| rise_en | input | 128 | Per-pin rising-edge enable |
| fall_en | input | 128 | Per-pin falling-edge enable |
| clr_mask | input | 128 | Write-one-to-clear strobe for status bits |
| cpu_halted | input | 1 | Processor halted flag |
| edge_status | output | 128 | Sticky edge status vector |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_shared | output | 1 | Interrupt for all other pins |
| wake_req | output | 1 | One-cycle wake request |

## Verification
The hardest situation to reach from the ports is the collision between a clear and an event on the same bit. It needs the clear mask raised in exactly the one cycle where the synchronized level differs from its delayed copy, two edges after the pin moves. A directed sequence first sets the bit, then re-arms the pin, and drives the clear on that precise cycle. Random stimulus toggles pins sparsely against random directions, enables, clears and halted flags. A cycle-accurate bench model is compared every cycle, which also catches wake pulses on pins at the borders of the four bank masks.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int BANK_W = 32;

    // Pins able to wake a halted processor, one word per bank of 32 pins.
    function automatic logic [BANK_W-1:0] wake_bank_mask(input int bank);
        logic [BANK_W-1:0] m;
        case (bank)
            0:       m = 32'h8003_FE1B;
            1:       m = 32'h0020_01FC;
            2:       m = 32'hEC08_0000;
            3:       m = 32'h0012_007F;
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_async,
    output logic [W-1:0] lvl_cur,
    output logic [W-1:0] lvl_prev
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] cur;
        logic [W-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.meta = pin_async;
        sync_d.cur  = sync_q.meta;
        sync_d.prev = sync_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign lvl_cur  = sync_q.cur;
    assign lvl_prev = sync_q.prev;

endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_cur,
    input  logic [W-1:0] lvl_prev,
    input  logic [W-1:0] dir_out,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status
);

    typedef struct packed {
        logic [W-1:0] sticky;
    } stat_t;

    stat_t        st_d, st_q;
    logic [W-1:0] rise_hit, fall_hit;

    always_comb begin
        rise_hit  = lvl_cur & ~lvl_prev & rise_en & ~dir_out;
        fall_hit  = ~lvl_cur & lvl_prev & fall_en & ~dir_out;
        st_d      = st_q;
        // The clear is applied first, so a new event in the same cycle survives it.
        st_d.sticky = (st_q.sticky & ~clr_mask) | rise_hit | fall_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.sticky;

endmodule

// File: rtl/gpio_wake_detect.sv
module gpio_wake_detect
    import gpio_edge_pkg::*;
#(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_cur,
    input  logic [W-1:0] lvl_prev,
    input  logic [W-1:0] dir_out,
    input  logic         cpu_halted,
    output logic         wake_req
);

    localparam int NBANK = W / BANK_W;

    logic [W-1:0] wake_mask;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign wake_mask[b*BANK_W +: BANK_W] = wake_bank_mask(b);
    end

    typedef struct packed {
        logic pulse;
    } wake_t;

    wake_t wk_d, wk_q;

    always_comb begin
        wk_d       = wk_q;
        wk_d.pulse = cpu_halted && |((lvl_cur ^ lvl_prev) & ~dir_out & wake_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wk_q <= '0;
        else        wk_q <= wk_d;
    end

    assign wake_req = wk_q.pulse;

endmodule

// File: rtl/gpio_irq_reduce.sv
module gpio_irq_reduce #(
    parameter int W = 128
) (
    input  logic [W-1:0] status,
    output logic         irq_pin0,
    output logic         irq_pin1,
    output logic         irq_shared
);

    always_comb begin
        irq_pin0   = status[0];
        irq_pin1   = status[1];
        irq_shared = |status[W-1:2];
    end

endmodule

// File: rtl/gpio_edge_router.sv
module gpio_edge_router
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_async,
    input  logic [NUM_PINS-1:0] dir_out,
    input  logic [NUM_PINS-1:0] rise_en,
    input  logic [NUM_PINS-1:0] fall_en,
    input  logic [NUM_PINS-1:0] clr_mask,
    input  logic                cpu_halted,
    output logic [NUM_PINS-1:0] edge_status,
    output logic                irq_pin0,
    output logic                irq_pin1,
    output logic                irq_shared,
    output logic                wake_req
);

    localparam int NBANK = NUM_PINS / BANK_W;

    initial begin
        if (NBANK * BANK_W != NUM_PINS || NBANK < 1)
            $error("NUM_PINS must be a positive multiple of %0d", BANK_W);
    end

    logic [NUM_PINS-1:0] lvl_cur, lvl_prev;

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_async),
        .lvl_cur   (lvl_cur),
        .lvl_prev  (lvl_prev)
    );

    gpio_edge_status #(.W(NUM_PINS)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_cur  (lvl_cur),
        .lvl_prev (lvl_prev),
        .dir_out  (dir_out),
        .rise_en  (rise_en),
        .fall_en  (fall_en),
        .clr_mask (clr_mask),
        .status   (edge_status)
    );

    gpio_wake_detect #(.W(NUM_PINS)) u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_cur    (lvl_cur),
        .lvl_prev   (lvl_prev),
        .dir_out    (dir_out),
        .cpu_halted (cpu_halted),
        .wake_req   (wake_req)
    );

    gpio_irq_reduce #(.W(NUM_PINS)) u_irq (
        .status     (edge_status),
        .irq_pin0   (irq_pin0),
        .irq_pin1   (irq_pin1),
        .irq_shared (irq_shared)
    );

endmodule

// File: rtl/gpio_edge_router_chk.sv
module gpio_edge_router_chk #(
    parameter int W = 128
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] dir_out,
    input logic [W-1:0] rise_en,
    input logic [W-1:0] fall_en,
    input logic [W-1:0] clr_mask,
    input logic         cpu_halted,
    input logic [W-1:0] edge_status,
    input logic         irq_pin0,
    input logic         irq_pin1,
    input logic         irq_shared,
    input logic         wake_req
);

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((edge_status & $past(edge_status) & ~$past(clr_mask))
                     == ($past(edge_status) & ~$past(clr_mask)))); // R4

    AST_OUTPUT_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((edge_status & ~$past(edge_status) & $past(dir_out)) == '0)); // R3

    AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((edge_status & ~$past(edge_status) & ~($past(rise_en) | $past(fall_en))) == '0)); // R1

    AST_WAKE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && wake_req) |-> $past(cpu_halted)); // R9

    AST_IRQ_DEDICATED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pin0 == edge_status[0]) && (irq_pin1 == edge_status[1])); // R6

    AST_IRQ_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_shared == (|edge_status[W-1:2])); // R7

endmodule

bind gpio_edge_router gpio_edge_router_chk #(.W(NUM_PINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dir_out     (dir_out),
    .rise_en     (rise_en),
    .fall_en     (fall_en),
    .clr_mask    (clr_mask),
    .cpu_halted  (cpu_halted),
    .edge_status (edge_status),
    .irq_pin0    (irq_pin0),
    .irq_pin1    (irq_pin1),
    .irq_shared  (irq_shared),
    .wake_req    (wake_req)
);

// File: tb/test_gpio_edge_router.sv
module test_gpio_edge_router;

    localparam int CLK_PERIOD = 10;
    localparam int N = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_async = '0, dir_out = '0, rise_en = '0, fall_en = '0, clr_mask = '0;
    logic         cpu_halted = 1'b0;
    logic [N-1:0] edge_status;
    logic         irq_pin0, irq_pin1, irq_shared, wake_req;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_router i_gpio_edge_router (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .dir_out(dir_out),
        .rise_en(rise_en), .fall_en(fall_en), .clr_mask(clr_mask),
        .cpu_halted(cpu_halted), .edge_status(edge_status), .irq_pin0(irq_pin0),
        .irq_pin1(irq_pin1), .irq_shared(irq_shared), .wake_req(wake_req)
    );

    // Wake bitmap per requirement R8.
    function automatic logic [N-1:0] exp_wake_mask();
        return {32'h0012_007F, 32'hEC08_0000, 32'h0020_01FC, 32'h8003_FE1B};
    endfunction

    function automatic logic [N-1:0] exp_events(input logic [N-1:0] now, input logic [N-1:0] was,
                                                input logic [N-1:0] d, input logic [N-1:0] r,
                                                input logic [N-1:0] f);
        return (now & ~was & r & ~d) | (~now & was & f & ~d);   // R1 R2 R3
    endfunction

    // Bench model of the three-edge pipeline.
    logic [N-1:0] m1, m2, m3, mst;
    logic         mwake;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m1 <= '0; m2 <= '0; m3 <= '0; mst <= '0; mwake <= 1'b0;
        end else begin
            m1    <= pin_async;
            m2    <= m1;
            m3    <= m2;
            mst   <= (mst & ~clr_mask) | exp_events(m2, m3, dir_out, rise_en, fall_en); // R4 R5
            mwake <= cpu_halted && |((m2 ^ m3) & ~dir_out & exp_wake_mask());           // R8 R9
        end
    end

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R1 R2 R4 status vs model", edge_status, mst);
        chk("R6 irq_pin0", {{(N-1){1'b0}}, irq_pin0}, {{(N-1){1'b0}}, mst[0]});
        chk("R6 irq_pin1", {{(N-1){1'b0}}, irq_pin1}, {{(N-1){1'b0}}, mst[1]});
        chk("R7 irq_shared", {{(N-1){1'b0}}, irq_shared}, {{(N-1){1'b0}}, |mst[N-1:2]});
        chk("R8 wake vs model", {{(N-1){1'b0}}, wake_req}, {{(N-1){1'b0}}, mwake});
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic rand_vec(output logic [N-1:0] v);
        v = {$urandom(), $urandom(), $urandom(), $urandom()};
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [N-1:0] rv;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 status after reset", edge_status, '0);
        chk("R10 outputs after reset", {{(N-4){1'b0}}, irq_pin0, irq_pin1, irq_shared, wake_req}, '0);

        // R1: rising edge on pin 5, three-edge latency
        rise_en = '1; fall_en = '0;
        pin_async[5] = 1'b1;
        step(); step();
        chk("R1 not yet set after two edges", edge_status, '0);
        // R5: clear on the collision cycle, while the event is live
        clr_mask[5] = 1'b1;
        step();
        clr_mask = '0;
        chk("R5 event beats clear", edge_status[5] ? 128'd1 : 128'd0, 128'd1);
        chk("R7 shared line for pin 5", {127'd0, irq_shared}, 128'd1);
        // R4: plain clear
        clr_mask[5] = 1'b1;
        step();
        clr_mask = '0;
        chk("R4 cleared", edge_status, '0);
        step();
        chk("R4 stays clear", edge_status, '0);

        // R2 and R6: falling edge on pin 0 with fall enable
        pin_async[0] = 1'b1; rise_en = '0; fall_en = '0;
        repeat (4) step();
        fall_en[0] = 1'b1;
        pin_async[0] = 1'b0;
        repeat (3) step();
        chk("R2 falling sets pin 0", edge_status, 128'd1);
        chk("R6 irq_pin0 high", {127'd0, irq_pin0}, 128'd1);
        clr_mask = '1; step(); clr_mask = '0;

        // R3: output pin toggles with both enables
        dir_out[1] = 1'b1; rise_en = '1; fall_en = '1;
        pin_async[1] = 1'b1;
        repeat (4) step();
        pin_async[1] = 1'b0;
        repeat (4) step();
        chk("R3 output pin ignored", edge_status, '0);
        dir_out = '0;

        // R8: wake on pin 0 while halted (bank 0 mask bit 0 set)
        cpu_halted = 1'b1; rise_en = '0; fall_en = '0;
        pin_async[0] = 1'b1;
        step(); step(); step();
        chk("R8 wake pulse", {127'd0, wake_req}, 128'd1);
        step();
        chk("R8 wake one cycle", {127'd0, wake_req}, 128'd0);
        // R9: pin 2 not in mask
        pin_async[2] = 1'b1;
        repeat (3) step();
        chk("R9 no wake outside mask", {127'd0, wake_req}, 128'd0);
        // R8: pin 127 (bank 3 bit 31 clear) and pin 95 (bank 2 bit 31 set)
        pin_async[95] = 1'b1;
        repeat (3) step();
        chk("R8 wake pin 95", {127'd0, wake_req}, 128'd1);
        // R9: not halted
        cpu_halted = 1'b0;
        pin_async[95] = 1'b0;
        repeat (3) step();
        chk("R9 no wake when running", {127'd0, wake_req}, 128'd0);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            rand_vec(rv);
            pin_async = pin_async ^ (rv & {$urandom(), $urandom(), $urandom(), $urandom()}
                                           & {$urandom(), $urandom(), $urandom(), $urandom()});
            if (($urandom() % 8) == 0) rand_vec(dir_out);
            if (($urandom() % 8) == 0) rand_vec(rise_en);
            if (($urandom() % 8) == 0) rand_vec(fall_en);
            if (($urandom() % 4) == 0) rand_vec(clr_mask); else clr_mask = '0;
            cpu_halted = $urandom() % 2;
            step();
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule